// File: doc/BRIEF.md
# Serial link fault transition monitor

This block judges whether a recovered serial bit stream is healthy. It takes one data sample per recovered bit clock and counts how long the line has gone without a change of level. If the line stays quiet for too long, the block declares a link fault. It then tells the clock-recovery loop to follow the local reference multiplied by eight rather than the incoming data, so the recovered clock cannot drift. The link is declared healthy again only when the data shows enough level changes within one fixed-length frame of bit times.

Two further inputs shape the verdict. A carrier-detect code selects one of three conditions. With carrier absent, the block reports a fault and forces the data copy low. With carrier present, the transition verdict and the lock flag together decide health. With the detector disabled, the transition verdict is ignored and only the out-of-lock flag from the frequency comparator is reported. The outputs follow a change of carrier code or lock flag in the same cycle. The transition detector keeps running underneath in every carrier mode.

Top module: `link_fault_monitor`

## Requirements
- R1: After reset the detector is in the fault state. With carrier present (code 01) and out_of_lock low, link_ok is 0 and track_ref is 1.
- R2: A sample is an edge when it differs from the sample taken one bit time earlier; the previous sample is taken as 0 right after reset. A pattern that changes level every second bit keeps a healthy link healthy indefinitely.
- R3: In the healthy state, the 512th consecutive sample without an edge moves the detector to the fault state at that sample's clock edge; 511 quiet samples do not.
- R4: In the fault state, samples fall into back-to-back frames of 512. The first frame starts on the first active clock after reset or after fault entry. Reaching 64 edges within one frame restores the healthy state at the clock edge that takes the 64th edge. The edge count restarts at each frame boundary, so 63 edges in a frame, or edges split across two frames, do not restore health.
- R5: With carrier present (code 01), link_ok = healthy AND NOT out_of_lock, and track_ref = NOT healthy.
- R6: With carrier absent (code 00), link_ok is 0, track_ref is 1 and rx_bit_gated is 0, whatever rx_bit carries.
- R7: With the detector disabled (code 10, and code 11 treated the same), link_ok = NOT out_of_lock and track_ref is 0, whatever the detector state.
- R8: In any carrier mode other than absent, rx_bit_gated equals rx_bit in the same cycle.
- R9: The detector keeps counting in every carrier mode. A change of cd_state changes the outputs in the same cycle, using the detector state built up meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_bit | input | 1 | Recovered data sample |
| cd_state | input | 2 | Carrier code: 00 absent, 01 present, 10/11 detector disabled |
| out_of_lock | input | 1 | High when the line rate is outside the lock range of the reference |
| link_ok | output | 1 | High when the link is judged healthy |
| track_ref | output | 1 | High when the recovery loop should follow reference x8 |
| rx_bit_gated | output | 1 | Recovered data, forced low while carrier is absent |

## Verification
Some properties are checked by assertions on every cycle. Any loss of health must follow a sample without an edge, and any regain must follow a sample with one. The quiet count never passes its saturation value and clears after every edge. The frame edge count never reaches the target without a recovery, and the window counters stay cleared while the link is healthy. Other properties can only be shown by the bench's scenarios against its own cycle model. These are the exact timeout at the 512th quiet sample, the 63 versus 64 edge threshold, edges that straddle a frame boundary, and a detector timeout that happens while the detector is disabled and becomes visible on return to carrier present.

// File: rtl/link_mon_pkg.sv
package link_mon_pkg;

  // Carrier code as seen at the cd_state port.
  typedef enum logic [1:0] {
    CD_ABSENT  = 2'b00,
    CD_PRESENT = 2'b01,
    CD_OFF     = 2'b10,
    CD_OFF_ALT = 2'b11
  } carrier_e;

endpackage

// File: rtl/lm_reset_sync.sv
module lm_reset_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_s = stage2_q;

endmodule

// File: rtl/lm_edge_detect.sv
module lm_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  output logic edge_seen
);

  logic prev_q;
  logic prev_d;
  logic prev_en;

  assign prev_en   = 1'b1;
  assign prev_d    = sample;
  assign edge_seen = sample ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/lm_quiet_timer.sv
module lm_quiet_timer #(
  parameter int QUIET_LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic timeout
);

  localparam int CW = $clog2(QUIET_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_C = CW'(QUIET_LIMIT);
  localparam logic [CW-1:0] LAST_C  = CW'(QUIET_LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (edge_seen) begin
      cnt_d = '0;
    end else if (cnt_q == LIMIT_C) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // This quiet sample completes the run of QUIET_LIMIT.
  assign timeout = !edge_seen && (cnt_q == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_quiet_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> (cnt_q == '0))
    else $error("quiet count not cleared after an edge");

  p_quiet_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT_C)
    else $error("quiet count beyond saturation");

endmodule

// File: rtl/lm_density_window.sv
module lm_density_window #(
  parameter int WINDOW_LEN = 512,
  parameter int MIN_EDGES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic edge_seen,
  output logic pass
);

  localparam int WW = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam logic [WW-1:0] WIN_LAST_C = WW'(WINDOW_LEN - 1);
  localparam logic [EW-1:0] TARGET_C   = EW'(MIN_EDGES);

  logic [WW-1:0] win_q, win_d;
  logic [EW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] sum;
  logic          win_en;

  assign sum  = cnt_q + EW'(edge_seen);
  assign pass = run && (sum >= TARGET_C);

  always_comb begin
    win_en = 1'b1;
    if (!run || pass || (win_q == WIN_LAST_C)) begin
      win_d = '0;
      cnt_d = '0;
    end else begin
      win_d = win_q + 1'b1;
      cnt_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (win_en) begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  p_below_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TARGET_C)
    else $error("frame edge count reached target without recovery");

  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (win_q == '0) && (cnt_q == '0))
    else $error("window counters not idle while healthy");

endmodule

// File: rtl/link_fault_monitor.sv
module link_fault_monitor
  import link_mon_pkg::*;
#(
  parameter int QUIET_LIMIT = 512,
  parameter int WINDOW_LEN  = 512,
  parameter int MIN_EDGES   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic [1:0] cd_state,
  input  logic       out_of_lock,
  output logic       link_ok,
  output logic       track_ref,
  output logic       rx_bit_gated
);

  logic     rst_s_n;
  logic     edge_seen;
  logic     timeout;
  logic     pass;
  logic     healthy_q;
  logic     healthy_d;
  logic     healthy_en;
  carrier_e cd;

  assign cd = carrier_e'(cd_state);

  lm_reset_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_s_n)
  );

  lm_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sample    (rx_bit),
    .edge_seen (edge_seen)
  );

  lm_quiet_timer #(.QUIET_LIMIT(QUIET_LIMIT)) u_quiet (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .edge_seen (edge_seen),
    .timeout   (timeout)
  );

  lm_density_window #(.WINDOW_LEN(WINDOW_LEN), .MIN_EDGES(MIN_EDGES)) u_win (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .run       (!healthy_q),
    .edge_seen (edge_seen),
    .pass      (pass)
  );

  // Detector verdict, independent of the carrier code.
  always_comb begin
    healthy_en = 1'b1;
    healthy_d  = healthy_q ? !timeout : pass;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      healthy_q <= 1'b0;
    end else if (healthy_en) begin
      healthy_q <= healthy_d;
    end
  end

  // Output selection follows the carrier code in the same cycle.
  always_comb begin
    unique case (cd)
      CD_ABSENT: begin
        link_ok      = 1'b0;
        track_ref    = 1'b1;
        rx_bit_gated = 1'b0;
      end
      CD_PRESENT: begin
        link_ok      = healthy_q && !out_of_lock;
        track_ref    = !healthy_q;
        rx_bit_gated = rx_bit;
      end
      default: begin
        link_ok      = !out_of_lock;
        track_ref    = 1'b0;
        rx_bit_gated = rx_bit;
      end
    endcase
  end

  p_fault_after_quiet_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(healthy_q) |-> $past(!edge_seen))
    else $error("fault entered on a sample that had an edge");

  p_recover_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(healthy_q) |-> $past(edge_seen))
    else $error("recovery on a sample without an edge");

endmodule

// File: tb/tb_link_fault_monitor.sv
`timescale 1ns/1ps
module tb_link_fault_monitor;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_bit;
  logic [1:0] cd_state;
  logic       out_of_lock;
  logic       link_ok, track_ref, rx_bit_gated;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // Behavioural reference state
  int m_quiet, m_win, m_edges, rel;
  bit m_healthy, m_prev;
  logic cur;

  always #2.5 clk = ~clk;

  link_fault_monitor dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .cd_state(cd_state),
    .out_of_lock(out_of_lock), .link_ok(link_ok), .track_ref(track_ref),
    .rx_bit_gated(rx_bit_gated)
  );

  task automatic model_clear();
    m_quiet = 0; m_win = 0; m_edges = 0; m_healthy = 0; m_prev = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear(); rel = 0;
    end else if (rel < 2) begin
      model_clear(); rel++;
    end else begin
      bit e;
      e = (rx_bit != m_prev);
      m_prev = rx_bit;
      if (e) m_quiet = 0; else if (m_quiet < 512) m_quiet++;
      if (m_healthy) begin
        if (m_quiet == 512) begin
          m_healthy = 0; m_win = 0; m_edges = 0;
        end
      end else begin
        m_edges += int'(e);
        if (m_edges >= 64) begin
          m_healthy = 1; m_win = 0; m_edges = 0;
        end else if (m_win == 511) begin
          m_win = 0; m_edges = 0;
        end else begin
          m_win++;
        end
      end
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic e_ok, e_tr, e_g;
    string tag;
    if (cd_state == 2'b00) begin
      e_ok = 0; e_tr = 1; e_g = 0; tag = "R6";
    end else if (cd_state[1]) begin
      e_ok = !out_of_lock; e_tr = 0; e_g = rx_bit; tag = "R7";
    end else begin
      e_ok = m_healthy && !out_of_lock; e_tr = !m_healthy; e_g = rx_bit; tag = "R5";
    end
    check(tag, "link_ok", link_ok, e_ok);
    check(tag, "track_ref", track_ref, e_tr);
    check((cd_state == 2'b00) ? "R6" : "R8", "rx_bit_gated", rx_bit_gated, e_g);
  endtask

  task automatic drive(logic b, logic [1:0] cd, logic ool);
    @(negedge clk);
    rx_bit = b; cd_state = cd; out_of_lock = ool;
    #1;
    compare_all();
  endtask

  task automatic toggle(logic [1:0] cd);
    cur = ~cur;
    drive(cur, cd, 1'b0);
  endtask

  // Hold the line until the next sample is index 0 of a fault frame.
  task automatic align_frame();
    while (m_healthy || m_win != 0) drive(cur, 2'b01, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_bit = 0; cd_state = 2'b01; out_of_lock = 0; cur = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    drive(0, 2'b01, 0);
    drive(0, 2'b01, 0);
    check("R1", "link_ok after reset", link_ok, 1'b0);
    check("R1", "track_ref after reset", track_ref, 1'b1);

    // R4: 63 edges in one frame do not recover
    align_frame();
    repeat (63) toggle(2'b01);
    align_frame();
    check("R4", "link_ok after 63 edges", link_ok, 1'b0);

    // R4: 40 + 40 edges split by a frame boundary do not recover
    while (m_win != 472) drive(cur, 2'b01, 0);
    repeat (80) toggle(2'b01);
    check("R4", "link_ok across boundary", link_ok, 1'b0);

    // R4: 64 spaced edges in one frame recover
    align_frame();
    for (int i = 0; i < 64; i++) begin
      toggle(2'b01);
      repeat (7) drive(cur, 2'b01, 0);
    end
    check("R4", "link_ok after 64 edges", link_ok, 1'b1);
    check("R4", "track_ref after 64 edges", track_ref, 1'b0);

    // R3: exact timeout at the 512th quiet sample
    toggle(2'b01);
    repeat (511) drive(cur, 2'b01, 0);
    drive(cur, 2'b01, 0);
    check("R3", "link_ok after 511 quiet", link_ok, 1'b1);
    drive(cur, 2'b01, 0);
    check("R3", "link_ok after 512 quiet", link_ok, 1'b0);
    check("R3", "track_ref after 512 quiet", track_ref, 1'b1);

    // Recover with 64 back-to-back edges, then R2 pattern 1,1,0,0
    align_frame();
    repeat (64) toggle(2'b01);
    for (int i = 0; i < 300; i++) begin
      toggle(2'b01);
      drive(cur, 2'b01, 0);
    end
    check("R2", "link_ok with two-bit runs", link_ok, 1'b1);

    // R5: lock loss while healthy
    drive(cur, 2'b01, 1);
    check("R5", "link_ok on out_of_lock", link_ok, 1'b0);
    check("R5", "track_ref on out_of_lock", track_ref, 1'b0);

    // R6 + R9: carrier absent, detector still runs
    drive(1'b1, 2'b00, 0); cur = 1'b1;
    check("R6", "rx_bit_gated absent", rx_bit_gated, 1'b0);
    check("R6", "link_ok absent", link_ok, 1'b0);
    check("R6", "track_ref absent", track_ref, 1'b1);
    repeat (20) toggle(2'b00);
    drive(cur, 2'b01, 0);
    check("R9", "link_ok back to present", link_ok, 1'b1);

    // R7 + R8 + R9: disabled detector, timeout occurs underneath
    repeat (520) drive(cur, 2'b10, 0);
    check("R7", "link_ok disabled, locked", link_ok, 1'b1);
    check("R7", "track_ref disabled", track_ref, 1'b0);
    drive(cur, 2'b10, 1);
    check("R7", "link_ok disabled, unlocked", link_ok, 1'b0);
    drive(cur, 2'b11, 0);
    check("R7", "link_ok code 11", link_ok, 1'b1);
    drive(1'b1, 2'b10, 0); cur = 1'b1;
    check("R8", "rx_bit_gated disabled high", rx_bit_gated, 1'b1);
    drive(1'b0, 2'b10, 0); cur = 1'b0;
    check("R8", "rx_bit_gated disabled low", rx_bit_gated, 1'b0);
    drive(1'b1, 2'b01, 0); cur = 1'b1;
    check("R8", "rx_bit_gated present", rx_bit_gated, 1'b1);
    check("R9", "link_ok after disabled timeout", link_ok, 1'b0);
    check("R9", "track_ref after disabled timeout", track_ref, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule